// File: doc/BRIEF.md
# Dual-View Banked Integer Register File

This block holds the integer architectural state of a load/store CPU core. It has thirty-one 64-bit general registers, four stack pointers (one for each privilege level 0 to 3), and, for levels 1 to 3 only, an exception return address and a 32-bit saved-status word. Two combinational read ports and one clocked write port each carry a 5-bit index, a narrow/wide size select and a decode-mode bit. Each port can therefore see a register either as its full 64 bits or as its low 32 bits, and each decodes index 31 either as a zero source/sink or as the stack pointer of the current level.

Register 30 is the link register. A dedicated link-write input loads a return address into it at full width, which call instructions use. A side port with its own level select reaches the banked exception return state. Decode, arithmetic, flags, exception sequencing and memory access belong to other blocks.

Top module: `intreg_file`

## Requirements
- R1: Indices 0 to 30 address 31 independent 64-bit general registers. A wide write to one of them becomes visible on both read ports from the next cycle.
- R2: A narrow read (size select = 1) returns bits 31:0 of the selected register in bits 31:0 of the read data, with bits 63:32 of the read data at zero.
- R3: A narrow write stores the low 32 bits of the write data and clears bits 63:32 of the target. Writing data 0xDEADBEEF_FFFFFFFF narrow gives 0x00000000_FFFFFFFF.
- R4: With the port's mode bit at 0 (zero decode), index 31 reads as zero, and a write to index 31 changes no general register and no stack pointer.
- R5: With the port's mode bit at 1 (stack decode), index 31 reaches the stack pointer chosen by the 2-bit current-level input. The four stack pointers are independent.
- R6: A narrow write to the stack pointer zero-extends in the same way as a narrow write to a general register.
- R7: The side port holds, for levels 1 to 3, a 64-bit return address and a 32-bit status word. Both are written together on the clock edge when the side write enable is 1, and both are read combinationally at the side level.
- R8: Side level 0 reads zero on both side outputs, and a side write at level 0 changes no stored value.
- R9: The link-write input loads its 64-bit address into register 30 on the clock edge.
- R10: When the normal write port and the link-write input both target register 30 in the same cycle, register 30 takes the normal write data.
- R11: A read in the same cycle as a write to the same register returns the value held before that write.
- R12: A synchronous active-high reset clears all general registers, stack pointers, return addresses and status words to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cur_lvl | input | 2 | Current privilege level, selects the stack pointer |
| ra_idx | input | 5 | Read port A index |
| ra_narrow | input | 1 | Read port A: 1 = 32-bit view |
| ra_stk | input | 1 | Read port A: 1 = index 31 is stack pointer, 0 = zero |
| ra_data | output | 64 | Read port A data |
| rb_idx | input | 5 | Read port B index |
| rb_narrow | input | 1 | Read port B: 1 = 32-bit view |
| rb_stk | input | 1 | Read port B: index 31 decode mode |
| rb_data | output | 64 | Read port B data |
| w_en | input | 1 | Write port enable |
| w_idx | input | 5 | Write port index |
| w_narrow | input | 1 | Write port: 1 = 32-bit zero-extending write |
| w_stk | input | 1 | Write port: index 31 decode mode |
| w_data | input | 64 | Write data |
| lnk_en | input | 1 | Link-register load enable |
| lnk_addr | input | 64 | Return address for register 30 |
| xr_lvl | input | 2 | Side port level select |
| xr_we | input | 1 | Side port write enable |
| xr_addr_wd | input | 64 | Side write data, return address |
| xr_stat_wd | input | 32 | Side write data, status word |
| xr_addr_rd | output | 64 | Side read data, return address |
| xr_stat_rd | output | 32 | Side read data, status word |

## Verification
The bench builds the block with its default parameters: 64-bit words, a 32-bit narrow view, a 5-bit index and four levels. With these values index 31 is the only decode corner, register 30 is the link target, and every level, including the level 0 that has no return state, can be reached directly from the 2-bit selects. The data patterns carry distinct upper and lower halves, so any fault in truncation or zero-extension shows up in the read data.

// File: rtl/intreg_pkg.sv
package intreg_pkg;
  localparam int unsigned XLEN_D  = 64;
  localparam int unsigned HALF_D  = 32;
  localparam int unsigned IDXW_D  = 5;
  localparam int unsigned NLVL_D  = 4;
  localparam int unsigned STATW_D = 32;

  typedef enum logic { VIEW_WIDE = 1'b0, VIEW_NARROW = 1'b1 } view_e;
  typedef enum logic { TOP_ZERO = 1'b0, TOP_STACK = 1'b1 } top_decode_e;
endpackage

// File: rtl/intreg_gpr.sv
module intreg_gpr #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned IDXW = 5,
  parameter int unsigned NRD  = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           we,
  input  logic [IDXW-1:0]                widx,
  input  logic [XLEN-1:0]                wdata,
  input  logic                           lnk_we,
  input  logic [XLEN-1:0]                lnk_data,
  input  logic [NRD-1:0][IDXW-1:0]       ridx,
  output logic [NRD-1:0][XLEN-1:0]       rdata
);
  localparam int unsigned NGPR = (1 << IDXW) - 1;
  localparam int unsigned LINK = NGPR - 1;

  logic [XLEN-1:0] q [NGPR];

  // normal port has priority over the link load on the link slot
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NGPR; i++) q[i] <= '0;
    end else begin
      for (int i = 0; i < NGPR; i++) begin
        if (we && widx == IDXW'(i))
          q[i] <= wdata;
        else if (lnk_we && i == LINK)
          q[i] <= lnk_data;
      end
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = (ridx[p] < IDXW'(NGPR)) ? q[ridx[p]] : '0;
  end
endmodule

// File: rtl/intreg_stkbank.sv
module intreg_stkbank #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned NLVL = 4,
  localparam int unsigned LVLW = (NLVL > 1) ? $clog2(NLVL) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [LVLW-1:0] lvl,
  input  logic            we,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] rdata
);
  logic [XLEN-1:0] sp [NLVL];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NLVL; i++) sp[i] <= '0;
    end else if (we) begin
      sp[lvl] <= wdata;
    end
  end

  assign rdata = sp[lvl];
endmodule

// File: rtl/intreg_retbank.sv
module intreg_retbank #(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned STATW = 32,
  parameter int unsigned NLVL  = 4,
  localparam int unsigned LVLW = (NLVL > 1) ? $clog2(NLVL) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVLW-1:0]  lvl,
  input  logic             we,
  input  logic [XLEN-1:0]  addr_wd,
  input  logic [STATW-1:0] stat_wd,
  output logic [XLEN-1:0]  addr_rd,
  output logic [STATW-1:0] stat_rd
);
  localparam int unsigned NBANK = NLVL - 1;

  logic [XLEN-1:0]  ret_q  [NBANK];
  logic [STATW-1:0] stat_q [NBANK];
  logic             has_bank;
  logic [LVLW-1:0]  slot;

  assign has_bank = (lvl != '0);
  assign slot     = lvl - LVLW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NBANK; i++) begin
        ret_q[i]  <= '0;
        stat_q[i] <= '0;
      end
    end else if (we && has_bank) begin
      ret_q[slot]  <= addr_wd;
      stat_q[slot] <= stat_wd;
    end
  end

  assign addr_rd = has_bank ? ret_q[slot]  : '0;
  assign stat_rd = has_bank ? stat_q[slot] : '0;
endmodule

// File: rtl/intreg_rport.sv
module intreg_rport
  import intreg_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned HALF = 32,
  parameter int unsigned IDXW = 5
) (
  input  logic [IDXW-1:0] idx,
  input  view_e           view,
  input  top_decode_e     decode,
  input  logic [XLEN-1:0] gpr_val,
  input  logic [XLEN-1:0] stk_val,
  output logic [XLEN-1:0] data
);
  logic            is_top;
  logic [XLEN-1:0] raw;

  assign is_top = (idx == '1);

  always_comb begin
    if (!is_top)                  raw = gpr_val;
    else if (decode == TOP_STACK) raw = stk_val;
    else                          raw = '0;
    data = (view == VIEW_NARROW) ? {{(XLEN-HALF){1'b0}}, raw[HALF-1:0]} : raw;
  end
endmodule

// File: rtl/intreg_file.sv
module intreg_file
  import intreg_pkg::*;
#(
  parameter int unsigned XLEN  = XLEN_D,
  parameter int unsigned HALF  = HALF_D,
  parameter int unsigned IDXW  = IDXW_D,
  parameter int unsigned NLVL  = NLVL_D,
  parameter int unsigned STATW = STATW_D,
  localparam int unsigned LVLW = (NLVL > 1) ? $clog2(NLVL) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVLW-1:0]  cur_lvl,
  input  logic [IDXW-1:0]  ra_idx,
  input  logic             ra_narrow,
  input  logic             ra_stk,
  output logic [XLEN-1:0]  ra_data,
  input  logic [IDXW-1:0]  rb_idx,
  input  logic             rb_narrow,
  input  logic             rb_stk,
  output logic [XLEN-1:0]  rb_data,
  input  logic             w_en,
  input  logic [IDXW-1:0]  w_idx,
  input  logic             w_narrow,
  input  logic             w_stk,
  input  logic [XLEN-1:0]  w_data,
  input  logic             lnk_en,
  input  logic [XLEN-1:0]  lnk_addr,
  input  logic [LVLW-1:0]  xr_lvl,
  input  logic             xr_we,
  input  logic [XLEN-1:0]  xr_addr_wd,
  input  logic [STATW-1:0] xr_stat_wd,
  output logic [XLEN-1:0]  xr_addr_rd,
  output logic [STATW-1:0] xr_stat_rd
);
  localparam int unsigned NRD = 2;

  logic [NRD-1:0][IDXW-1:0] rd_idx;
  logic [NRD-1:0]           rd_narrow;
  logic [NRD-1:0]           rd_stk;
  logic [NRD-1:0][XLEN-1:0] rd_gpr;
  logic [NRD-1:0][XLEN-1:0] rd_out;

  logic            w_top;
  logic [XLEN-1:0] w_val;
  logic            gpr_we;
  logic            stk_we;
  logic [XLEN-1:0] stk_val;

  assign rd_idx    = {rb_idx, ra_idx};
  assign rd_narrow = {rb_narrow, ra_narrow};
  assign rd_stk    = {rb_stk, ra_stk};
  assign ra_data   = rd_out[0];
  assign rb_data   = rd_out[1];

  // write-side view: narrow writes zero-extend for both targets
  assign w_top  = (w_idx == '1);
  assign w_val  = w_narrow ? {{(XLEN-HALF){1'b0}}, w_data[HALF-1:0]} : w_data;
  assign gpr_we = w_en && !w_top;
  assign stk_we = w_en && w_top && w_stk;

  intreg_gpr #(.XLEN(XLEN), .IDXW(IDXW), .NRD(NRD)) u_gpr (
    .clk      (clk),
    .rst      (rst),
    .we       (gpr_we),
    .widx     (w_idx),
    .wdata    (w_val),
    .lnk_we   (lnk_en),
    .lnk_data (lnk_addr),
    .ridx     (rd_idx),
    .rdata    (rd_gpr)
  );

  intreg_stkbank #(.XLEN(XLEN), .NLVL(NLVL)) u_stk (
    .clk   (clk),
    .rst   (rst),
    .lvl   (cur_lvl),
    .we    (stk_we),
    .wdata (w_val),
    .rdata (stk_val)
  );

  intreg_retbank #(.XLEN(XLEN), .STATW(STATW), .NLVL(NLVL)) u_ret (
    .clk     (clk),
    .rst     (rst),
    .lvl     (xr_lvl),
    .we      (xr_we),
    .addr_wd (xr_addr_wd),
    .stat_wd (xr_stat_wd),
    .addr_rd (xr_addr_rd),
    .stat_rd (xr_stat_rd)
  );

  for (genvar p = 0; p < NRD; p++) begin : g_port
    intreg_rport #(.XLEN(XLEN), .HALF(HALF), .IDXW(IDXW)) u_rp (
      .idx     (rd_idx[p]),
      .view    (view_e'(rd_narrow[p])),
      .decode  (top_decode_e'(rd_stk[p])),
      .gpr_val (rd_gpr[p]),
      .stk_val (stk_val),
      .data    (rd_out[p])
    );
  end
endmodule

// File: rtl/intreg_file_chk.sv
module intreg_file_chk #(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned HALF  = 32,
  parameter int unsigned IDXW  = 5,
  parameter int unsigned NLVL  = 4,
  parameter int unsigned STATW = 32,
  localparam int unsigned LVLW = (NLVL > 1) ? $clog2(NLVL) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic [LVLW-1:0]  cur_lvl,
  input logic [IDXW-1:0]  ra_idx,
  input logic             ra_narrow,
  input logic             ra_stk,
  input logic [XLEN-1:0]  ra_data,
  input logic [IDXW-1:0]  rb_idx,
  input logic             rb_narrow,
  input logic             rb_stk,
  input logic [XLEN-1:0]  rb_data,
  input logic             w_en,
  input logic [IDXW-1:0]  w_idx,
  input logic             w_narrow,
  input logic             w_stk,
  input logic [XLEN-1:0]  w_data,
  input logic             lnk_en,
  input logic [XLEN-1:0]  lnk_addr,
  input logic [LVLW-1:0]  xr_lvl,
  input logic             xr_we,
  input logic [XLEN-1:0]  xr_addr_wd,
  input logic [STATW-1:0] xr_stat_wd,
  input logic [XLEN-1:0]  xr_addr_rd,
  input logic [STATW-1:0] xr_stat_rd
);
  localparam logic [IDXW-1:0] TOP  = '1;
  localparam logic [IDXW-1:0] LINK = TOP - IDXW'(1);

  AST_WIDE_WRITE_SEEN: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(w_en && !w_narrow && w_idx != TOP) && rb_idx == $past(w_idx)
     && !rb_narrow && !($past(lnk_en) && rb_idx == LINK && $past(w_idx) != LINK))
    |-> rb_data == $past(w_data)); // R1

  AST_NARROW_READ_UPPER: assert property (@(posedge clk) disable iff (rst)
    ra_narrow |-> ra_data[XLEN-1:HALF] == '0); // R2

  AST_NARROW_WRITE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(w_en && w_narrow && w_idx != TOP) && ra_idx == $past(w_idx)
     && !ra_narrow && !($past(lnk_en) && ra_idx == LINK && $past(w_idx) != LINK))
    |-> ra_data == {{(XLEN-HALF){1'b0}}, $past(w_data[HALF-1:0])}); // R3

  AST_TOP_ZERO_READ: assert property (@(posedge clk) disable iff (rst)
    (ra_idx == TOP && !ra_stk) |-> ra_data == '0); // R4

  AST_SIDE_LVL0_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (xr_lvl == '0) |-> (xr_addr_rd == '0 && xr_stat_rd == '0)); // R8

  AST_LINK_LOAD: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(lnk_en && !(w_en && w_idx == LINK)) && ra_idx == LINK && !ra_narrow)
    |-> ra_data == $past(lnk_addr)); // R9

  AST_NORMAL_BEATS_LINK: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(lnk_en && w_en && w_idx == LINK && !w_narrow)
     && rb_idx == LINK && !rb_narrow)
    |-> rb_data == $past(w_data)); // R10

  AST_RESET_CLEARS: assert property (@(posedge clk)
    ($past(rst) && !rst && ra_idx != LINK) |-> ra_data == '0); // R12
endmodule

bind intreg_file intreg_file_chk #(
  .XLEN(XLEN), .HALF(HALF), .IDXW(IDXW), .NLVL(NLVL), .STATW(STATW)
) u_chk (.*);

// File: tb/sim_intreg_file.sv
`timescale 1ns/1ps
module sim_intreg_file;
  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  cur_lvl;
  logic [4:0]  ra_idx, rb_idx, w_idx;
  logic        ra_narrow, ra_stk, rb_narrow, rb_stk;
  logic [63:0] ra_data, rb_data;
  logic        w_en, w_narrow, w_stk;
  logic [63:0] w_data;
  logic        lnk_en;
  logic [63:0] lnk_addr;
  logic [1:0]  xr_lvl;
  logic        xr_we;
  logic [63:0] xr_addr_wd, xr_addr_rd;
  logic [31:0] xr_stat_wd, xr_stat_rd;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  intreg_file u0 (.*);

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, got hang expected completion");
      report();
    end
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    w_en = 0; lnk_en = 0; xr_we = 0;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk); idle();
  endtask

  task automatic put(logic [4:0] i, logic nar, logic stk, logic [63:0] d);
    w_en = 1; w_idx = i; w_narrow = nar; w_stk = stk; w_data = d;
    tick();
  endtask

  task automatic peek(logic [4:0] i, logic nar, logic stk, output logic [63:0] d);
    ra_idx = i; ra_narrow = nar; ra_stk = stk; #1 d = ra_data;
  endtask

  task automatic peek_b(logic [4:0] i, logic nar, logic stk, output logic [63:0] d);
    rb_idx = i; rb_narrow = nar; rb_stk = stk; #1 d = rb_data;
  endtask

  task automatic do_reset();
    rst = 1; idle(); tick(); tick(); rst = 0;
  endtask

  task automatic t_reset_state(string req);
    logic [63:0] v;
    int bad = 0;
    for (int i = 0; i < 31; i++) begin
      peek(5'(i), 0, 0, v); if (v !== 64'h0) bad++;
    end
    check({req, " gprs zero"}, 64'(bad), 64'h0);
    for (int l = 0; l < 4; l++) begin
      cur_lvl = 2'(l); peek(5'd31, 0, 1, v);
      check({req, " stack zero"}, v, 64'h0);
    end
    for (int l = 1; l < 4; l++) begin
      xr_lvl = 2'(l); #1;
      check({req, " ret addr zero"}, xr_addr_rd, 64'h0);
      check({req, " status zero"}, 64'(xr_stat_rd), 64'h0);
    end
  endtask

  task automatic t_wide(); // R1
    logic [63:0] v;
    for (int i = 0; i < 31; i++) put(5'(i), 0, 0, {32'(i) ^ 32'hA5A5_0000, 32'(i) * 32'h0101_0101});
    for (int i = 0; i < 31; i++) begin
      peek(5'(i), 0, 0, v);
      check("R1 port A", v, {32'(i) ^ 32'hA5A5_0000, 32'(i) * 32'h0101_0101});
      peek_b(5'(i), 0, 0, v);
      check("R1 port B", v, {32'(i) ^ 32'hA5A5_0000, 32'(i) * 32'h0101_0101});
    end
  endtask

  task automatic t_narrow_read(); // R2
    logic [63:0] v;
    put(5'd5, 0, 0, 64'h0123_4567_89AB_CDEF);
    peek(5'd5, 1, 0, v);   check("R2 narrow read A", v, 64'h0000_0000_89AB_CDEF);
    peek_b(5'd5, 1, 1, v); check("R2 narrow read B", v, 64'h0000_0000_89AB_CDEF);
    peek(5'd5, 0, 0, v);   check("R2 wide intact", v, 64'h0123_4567_89AB_CDEF);
  endtask

  task automatic t_narrow_write(); // R3
    logic [63:0] v;
    put(5'd9, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    put(5'd9, 1, 0, 64'hDEAD_BEEF_FFFF_FFFF);
    peek(5'd9, 0, 0, v); check("R3 zero-extend", v, 64'h0000_0000_FFFF_FFFF);
    put(5'd12, 1, 1, 64'h1234_5678_0000_0001);
    peek(5'd12, 0, 0, v); check("R3 zero-extend small", v, 64'h0000_0000_0000_0001);
  endtask

  task automatic t_zero_top(); // R4
    logic [63:0] v;
    cur_lvl = 2'd2;
    put(5'd31, 0, 1, 64'hAAAA_0000_BBBB_1111);
    put(5'd30, 0, 0, 64'h3030_3030_3030_3030);
    put(5'd31, 0, 0, 64'hFFFF_EEEE_DDDD_CCCC);
    peek(5'd31, 0, 0, v); check("R4 zero read A", v, 64'h0);
    peek_b(5'd31, 0, 0, v); check("R4 zero read B", v, 64'h0);
    peek(5'd31, 0, 1, v); check("R4 stack untouched", v, 64'hAAAA_0000_BBBB_1111);
    peek(5'd30, 0, 0, v); check("R4 gpr30 untouched", v, 64'h3030_3030_3030_3030);
  endtask

  task automatic t_stack_banks(); // R5
    logic [63:0] v;
    for (int l = 0; l < 4; l++) begin
      cur_lvl = 2'(l); put(5'd31, 0, 1, 64'h5000_0000_0000_0000 | 64'(l * 16 + 8));
    end
    for (int l = 3; l >= 0; l--) begin
      cur_lvl = 2'(l);
      peek(5'd31, 0, 1, v); check("R5 bank A", v, 64'h5000_0000_0000_0000 | 64'(l * 16 + 8));
      peek_b(5'd31, 0, 1, v); check("R5 bank B", v, 64'h5000_0000_0000_0000 | 64'(l * 16 + 8));
    end
  endtask

  task automatic t_stack_narrow(); // R6
    logic [63:0] v;
    cur_lvl = 2'd1;
    put(5'd31, 1, 1, 64'h7777_8888_9999_AAAA);
    peek(5'd31, 0, 1, v); check("R6 stack zero-extend", v, 64'h0000_0000_9999_AAAA);
    cur_lvl = 2'd3;
    peek(5'd31, 0, 1, v); check("R6 other bank kept", v, 64'h5000_0000_0000_0038);
  endtask

  task automatic t_side(); // R7, R8
    for (int l = 1; l < 4; l++) begin
      xr_lvl = 2'(l); xr_we = 1;
      xr_addr_wd = 64'hE000_0000_0000_1000 + 64'(l); xr_stat_wd = 32'h0000_03C0 | 32'(l);
      tick();
    end
    xr_lvl = 2'd0; xr_we = 1; xr_addr_wd = 64'hFFFF_FFFF_FFFF_FFFF; xr_stat_wd = 32'hFFFF_FFFF;
    tick();
    #1 check("R8 lvl0 addr reads zero", xr_addr_rd, 64'h0);
    check("R8 lvl0 status reads zero", 64'(xr_stat_rd), 64'h0);
    for (int l = 1; l < 4; l++) begin
      xr_lvl = 2'(l); #1;
      check("R7/R8 ret addr", xr_addr_rd, 64'hE000_0000_0000_1000 + 64'(l));
      check("R7/R8 status", 64'(xr_stat_rd), 64'(32'h0000_03C0 | 32'(l)));
    end
  endtask

  task automatic t_link(); // R9, R10
    logic [63:0] v;
    lnk_en = 1; lnk_addr = 64'hFFFF_8000_1234_5678;
    w_en = 1; w_idx = 5'd3; w_narrow = 0; w_stk = 0; w_data = 64'h0303_0303_0303_0303;
    tick();
    peek(5'd30, 0, 0, v); check("R9 link load", v, 64'hFFFF_8000_1234_5678);
    peek(5'd3, 0, 0, v); check("R9 parallel write", v, 64'h0303_0303_0303_0303);
    lnk_en = 1; lnk_addr = 64'h1111_1111_1111_1111;
    w_en = 1; w_idx = 5'd30; w_narrow = 0; w_stk = 0; w_data = 64'h2222_3333_4444_5555;
    tick();
    peek(5'd30, 0, 0, v); check("R10 normal wins", v, 64'h2222_3333_4444_5555);
  endtask

  task automatic t_rdw(); // R11
    put(5'd7, 0, 0, 64'h0000_0000_0000_0077);
    ra_idx = 5'd7; ra_narrow = 0; ra_stk = 0;
    w_en = 1; w_idx = 5'd7; w_narrow = 0; w_stk = 0; w_data = 64'h7070_7070_7070_7070;
    #1 check("R11 old value same cycle", ra_data, 64'h0000_0000_0000_0077);
    tick();
    #1 check("R11 new value next cycle", ra_data, 64'h7070_7070_7070_7070);
  endtask

  initial begin
    cur_lvl = 0; ra_idx = 0; rb_idx = 0; ra_narrow = 0; rb_narrow = 0;
    ra_stk = 0; rb_stk = 0; w_idx = 0; w_narrow = 0; w_stk = 0; w_data = 0;
    lnk_addr = 0; xr_lvl = 0; xr_addr_wd = 0; xr_stat_wd = 0;
    idle();
    @(negedge clk);
    do_reset();
    t_reset_state("R12 initial");
    t_wide();
    t_narrow_read();
    t_narrow_write();
    t_zero_top();
    t_stack_banks();
    t_stack_narrow();
    t_side();
    t_link();
    t_rdw();
    do_reset();
    t_reset_state("R12 after use");
    finished = 1;
    report();
  end
endmodule